// File: doc/BRIEF.md
# Word FIFO with Sticky Error and Watermark Status

This block is a word-wide first-in first-out buffer reached through one small register interface. A single data location is the FIFO itself: a write there pushes one word and a read there pops one word. The read result appears on the read-data output one clock after the read access. A status location reports the live fill state, which is full, empty and two watermark alarms. It also holds sticky error flags that record overflow, underflow and malformed accesses until software clears them.

Only whole-word accesses are legal on the data location. An access with any byte lane disabled moves nothing and raises the aggregate error flag. The alarms compare the occupancy and the free space against a granularity value held in a control location. The same control location can flush the buffer. A flush empties the FIFO and withdraws the overflow and underflow records.

Register map, selected by `acc_sel`: 0 is the data port, 1 is status, 2 is control, and 3 is unused.

Top module: `flagged_word_fifo`

## Requirements
- R1: After reset the status word reads 0x0003_0000, with only empty (bit 16) and low alarm (bit 17) set. The control word reads granularity 8.
- R2: A data write with all four byte enables set pushes the word while the FIFO is not full. A full-width data read pops the words in arrival order, and each word appears on `acc_rdata` the cycle after the read access.
- R3: Status bit 19 (full) is 1 exactly when 16 words are stored, and bit 16 (empty) is 1 exactly when none are stored. Both follow the occupancy with no memory of earlier states.
- R4: A full-width data write while the FIFO is full is discarded and leaves the stored words unchanged. It sets overflow (status bit 20) and error (bit 22).
- R5: A full-width data read while the FIFO is empty returns 0 and moves nothing. It sets underflow (status bit 21) and error (bit 22).
- R6: A data access with any byte enable deasserted neither pushes nor pops. A read of this kind returns 0. The access sets error (bit 22) and leaves overflow and underflow as they were.
- R7: Writing the status word clears underflow where bit 21 is 1 and clears overflow where bit 20 is 1. Bit 22 clears error only if neither underflow nor overflow remains set after that same write. Zero bits change nothing, and all flags are otherwise sticky.
- R8: High alarm (bit 18) is 1 while occupancy is greater than or equal to the granularity. Low alarm (bit 17) is 1 while free space (16 minus occupancy) is greater than or equal to the granularity.
- R9: A control write loads the granularity from bits 4:0. If bit 31 is 1, the same write also flushes the FIFO to empty and clears underflow and overflow, while error keeps its value. A control read returns the granularity in bits 4:0 and 0 elsewhere.
- R10: Status bits other than 22:16 read 0, and a read with `acc_sel` = 3 returns 0. Status and control writes take effect whatever the byte enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per asserted cycle |
| acc_wr | input | 1 | 1 for a write, 0 for a read |
| acc_sel | input | 2 | Location: 0 data, 1 status, 2 control, 3 unused |
| acc_be | input | 4 | Byte enables, all required on the data location |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, registered, updated after each read access |

## Verification
One status write can do two things in the same cycle: it clears underflow or overflow, and it clears error only on the condition that those flags end up clear after that write. The bench writes status words that clear only one of two set flags together with the error bit, and words that clear both together with the error bit. A following status read is compared with a bench model that applies the flag clears before it judges whether error may drop. In the same way, a control write that flushes and loads a new granularity at once is checked through the fill flags and alarms that the next status read returns.

// File: rtl/flagfifo_pkg.sv
package flagfifo_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } sel_e;

   // status word bit positions (lsb-0)
   localparam int ST_EMPTY = 16;
   localparam int ST_LO    = 17;
   localparam int ST_HI    = 18;
   localparam int ST_FULL  = 19;
   localparam int ST_OF    = 20;
   localparam int ST_UF    = 21;
   localparam int ST_ERR   = 22;

   // control word
   localparam int CTRL_FLUSH = 31;

   typedef struct packed {
      logic err;
      logic uf;
      logic of;
      logic full;
      logic hi;
      logic lo;
      logic empty;
   } stat_t;

endpackage

// File: rtl/ffq_ptrs.sv
module ffq_ptrs #(
   parameter  int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             flush,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] rd_idx,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             empty
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] wr_q;
   logic [CNT_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
      end
   end

   assign wr_idx = wr_q[PTR_W-1:0];
   assign rd_idx = rd_q[PTR_W-1:0];
   assign count  = wr_q - rd_q;
   assign full   = (count == DEPTH_C);
   assign empty  = (count == '0);

   // R3
   full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   // R3
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_C);

   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/ffq_store.sv
module ffq_store #(
   parameter  int DEPTH     = 16,
   parameter  int DATA_W    = 32,
   parameter  bit CLEAR_MEM = 1'b0,
   localparam int PTR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_MEM) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_plain
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

endmodule

// File: rtl/ffq_flags.sv
module ffq_flags
   import flagfifo_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_of,
   input  logic             ev_uf,
   input  logic             ev_be,
   input  logic             flush,
   input  logic             clr_uf,
   input  logic             clr_of,
   input  logic             clr_err,
   input  logic [CNT_W-1:0] count,
   input  logic             full,
   input  logic             empty,
   input  logic [CNT_W-1:0] gran,
   output stat_t            st
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic uf_q, of_q, err_q;
   logic uf_d, of_d, err_d;
   logic [CNT_W-1:0] free_cnt;

   always_comb begin
      uf_d  = ev_uf | (uf_q & ~clr_uf & ~flush);
      of_d  = ev_of | (of_q & ~clr_of & ~flush);
      err_d = ev_uf | ev_of | ev_be |
              (err_q & ~(clr_err & ~uf_d & ~of_d));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uf_q  <= 1'b0;
         of_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         uf_q  <= uf_d;
         of_q  <= of_d;
         err_q <= err_d;
      end
   end

   assign free_cnt = DEPTH_C - count;

   assign st.err   = err_q;
   assign st.uf    = uf_q;
   assign st.of    = of_q;
   assign st.full  = full;
   assign st.hi    = (count >= gran);
   assign st.lo    = (free_cnt >= gran);
   assign st.empty = empty;

   // R7
   uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_q && !clr_uf && !flush) |=> uf_q);

   // R7
   of_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (of_q && !clr_of && !flush) |=> of_q);

   // R7
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr_err) |=> err_q);

   // R5
   uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_uf |=> (uf_q && err_q));

endmodule

// File: rtl/flagged_word_fifo.sv
module flagged_word_fifo
   import flagfifo_pkg::*;
#(
   parameter  int DATA_W    = 32,
   parameter  int DEPTH     = 16,
   parameter  int GRAN_RST  = 8,
   parameter  bit CLEAR_MEM = 1'b0,
   localparam int BE_W      = DATA_W / 8,
   localparam int PTR_W     = $clog2(DEPTH),
   localparam int CNT_W     = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [1:0]        acc_sel,
   input  logic [BE_W-1:0]   acc_be,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata
);

   // elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 32");
   end
   if (GRAN_RST < 0 || GRAN_RST > DEPTH) begin : g_bad_gran
      $error("GRAN_RST must lie within 0..DEPTH");
   end

   sel_e             sel;
   logic             full_be;
   logic             data_acc, stat_wr, ctrl_wr;
   logic             push, pop, flush;
   logic             ev_of, ev_uf, ev_be;
   logic             clr_uf, clr_of, clr_err;
   logic [PTR_W-1:0] wr_idx, rd_idx;
   logic [CNT_W-1:0] count;
   logic             full, empty;
   logic [CNT_W-1:0] gran_q;
   logic [DATA_W-1:0] head_word;
   logic [DATA_W-1:0] rd_word;
   stat_t            st;

   assign sel      = sel_e'(acc_sel);
   assign full_be  = &acc_be;
   assign data_acc = acc_en && (sel == SEL_DATA);
   assign stat_wr  = acc_en && acc_wr && (sel == SEL_STAT);
   assign ctrl_wr  = acc_en && acc_wr && (sel == SEL_CTRL);

   assign push  = data_acc &&  acc_wr && full_be && !full;
   assign pop   = data_acc && !acc_wr && full_be && !empty;
   assign ev_of = data_acc &&  acc_wr && full_be &&  full;
   assign ev_uf = data_acc && !acc_wr && full_be &&  empty;
   assign ev_be = data_acc && !full_be;

   assign clr_uf  = stat_wr && acc_wdata[ST_UF];
   assign clr_of  = stat_wr && acc_wdata[ST_OF];
   assign clr_err = stat_wr && acc_wdata[ST_ERR];
   assign flush   = ctrl_wr && acc_wdata[CTRL_FLUSH];

   ffq_ptrs #(.DEPTH(DEPTH)) i_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .pop    (pop),
      .flush  (flush),
      .wr_idx (wr_idx),
      .rd_idx (rd_idx),
      .count  (count),
      .full   (full),
      .empty  (empty)
   );

   ffq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CLEAR_MEM(CLEAR_MEM)) i_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (push),
      .waddr  (wr_idx),
      .wdata  (acc_wdata),
      .raddr  (rd_idx),
      .rdata  (head_word)
   );

   ffq_flags #(.DEPTH(DEPTH)) i_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_of   (ev_of),
      .ev_uf   (ev_uf),
      .ev_be   (ev_be),
      .flush   (flush),
      .clr_uf  (clr_uf),
      .clr_of  (clr_of),
      .clr_err (clr_err),
      .count   (count),
      .full    (full),
      .empty   (empty),
      .gran    (gran_q),
      .st      (st)
   );

   // granularity register
   always_ff @(posedge clk) begin
      if (!rst_n)       gran_q <= CNT_W'(GRAN_RST);
      else if (ctrl_wr) gran_q <= acc_wdata[CNT_W-1:0];
   end

   // read word selection
   always_comb begin
      rd_word = '0;
      unique case (sel)
         SEL_DATA: if (pop) rd_word = head_word;
         SEL_STAT: begin
            rd_word[ST_ERR]   = st.err;
            rd_word[ST_UF]    = st.uf;
            rd_word[ST_OF]    = st.of;
            rd_word[ST_FULL]  = st.full;
            rd_word[ST_HI]    = st.hi;
            rd_word[ST_LO]    = st.lo;
            rd_word[ST_EMPTY] = st.empty;
         end
         SEL_CTRL: rd_word[CNT_W-1:0] = gran_q;
         default:  rd_word = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                acc_rdata <= '0;
      else if (acc_en && !acc_wr) acc_rdata <= rd_word;
   end

   // R2
   pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (count == $past(count) - 1'b1));

   // R4
   of_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_of |=> (count == $past(count) && st.of && st.err));

   // R5
   uf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_uf |=> (acc_rdata == '0 && empty));

   // R6
   be_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_be |=> (st.err && count == $past(count)));

endmodule

// File: tb/test_flagged_word_fifo.sv
`timescale 1ns/1ps
module test_flagged_word_fifo;

   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic [1:0]  acc_sel = 2'd0;
   logic [3:0]  acc_be = 4'h0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model
   logic [31:0] mq[$];
   bit m_uf = 0, m_of = 0, m_err = 0;
   int m_gran = 8;

   always #5 clk = ~clk;

   flagged_word_fifo i_flagged_word_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_en    (acc_en),
      .acc_wr    (acc_wr),
      .acc_sel   (acc_sel),
      .acc_be    (acc_be),
      .acc_wdata (acc_wdata),
      .acc_rdata (acc_rdata)
   );

   function automatic logic [31:0] m_status();
      logic [31:0] s;
      int n;
      n = mq.size();
      s = '0;
      s[22] = m_err;
      s[21] = m_uf;
      s[20] = m_of;
      s[19] = (n == DEPTH);
      s[18] = (n >= m_gran);
      s[17] = ((DEPTH - n) >= m_gran);
      s[16] = (n == 0);
      return s;
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] expv);
      n_vec++;
      if (got !== expv) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, expv);
      end
   endtask

   task automatic access(input logic wr, input logic [1:0] sel, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      acc_en = 1'b1; acc_wr = wr; acc_sel = sel; acc_be = be; acc_wdata = wd;
      @(negedge clk);
      acc_en = 1'b0;
      rd = acc_rdata;
   endtask

   // one access, model update and check of any read result
   task automatic op(input logic wr, input logic [1:0] sel, input logic [3:0] be,
                     input logic [31:0] wd, input string tag);
      logic [31:0] got, expv;
      expv = '0;
      case (sel)
         2'd0: begin
            if (wr) begin
               if (be == 4'hF) begin
                  if (mq.size() == DEPTH) begin m_of = 1; m_err = 1; end
                  else mq.push_back(wd);
               end else m_err = 1;
            end else begin
               if (be == 4'hF) begin
                  if (mq.size() == 0) begin m_uf = 1; m_err = 1; expv = '0; end
                  else expv = mq.pop_front();
               end else begin m_err = 1; expv = '0; end
            end
         end
         2'd1: begin
            if (wr) begin
               if (wd[21]) m_uf = 0;
               if (wd[20]) m_of = 0;
               if (wd[22] && !m_uf && !m_of) m_err = 0;
            end else expv = m_status();
         end
         2'd2: begin
            if (wr) begin
               m_gran = int'(wd[4:0]);
               if (wd[31]) begin mq.delete(); m_uf = 0; m_of = 0; end
            end else expv = 32'(m_gran);
         end
         default: expv = '0;
      endcase
      access(wr, sel, be, wd, got);
      if (!wr) check(tag, got, expv);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0F1F));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      op(0, 2'd1, 4'hF, 0, "R1");
      check("R1", m_status(), 32'h0003_0000);
      op(0, 2'd2, 4'hF, 0, "R1");
      // R10 unused location and reserved bits
      op(0, 2'd3, 4'hF, 0, "R10");

      // R2 R3 R8 fill the FIFO
      for (int i = 0; i < DEPTH; i++) begin
         op(1, 2'd0, 4'hF, 32'hA500_0000 + i, "R2");
         if (i == 6 || i == 7 || i == 8) op(0, 2'd1, 4'hF, 0, "R8");
      end
      op(0, 2'd1, 4'hF, 0, "R3");
      // R4 overflow, contents untouched
      op(1, 2'd0, 4'hF, 32'hDEAD_BEEF, "R4");
      op(0, 2'd1, 4'hF, 0, "R4");
      for (int i = 0; i < DEPTH; i++) op(0, 2'd0, 4'hF, 0, "R4");
      // R5 underflow
      op(0, 2'd0, 4'hF, 0, "R5");
      op(0, 2'd1, 4'hF, 0, "R5");
      // R7 clear underflow and error only: error stays (overflow still set)
      op(1, 2'd1, 4'h0, 32'h0060_0000, "R7");
      op(0, 2'd1, 4'hF, 0, "R7");
      // R7 clear overflow and error together
      op(1, 2'd1, 4'hF, 32'h0050_0000, "R7");
      op(0, 2'd1, 4'hF, 0, "R7");
      // R6 partial byte enables
      op(1, 2'd0, 4'h7, 32'h1111_1111, "R6");
      op(0, 2'd1, 4'hF, 0, "R6");
      op(1, 2'd0, 4'hF, 32'h2222_2222, "R6");
      op(0, 2'd0, 4'hE, 0, "R6");
      op(0, 2'd1, 4'hF, 0, "R6");
      op(0, 2'd0, 4'hF, 0, "R6");
      op(1, 2'd1, 4'hF, 32'h0040_0000, "R7");
      op(0, 2'd1, 4'hF, 0, "R7");
      // R8 granularity boundaries
      op(1, 2'd2, 4'hF, 32'd0, "R8");
      op(0, 2'd1, 4'hF, 0, "R8");
      op(1, 2'd2, 4'hF, 32'd16, "R8");
      op(0, 2'd2, 4'hF, 0, "R9");
      op(0, 2'd1, 4'hF, 0, "R8");
      // R9 flush with new granularity in one write
      op(0, 2'd0, 4'hF, 0, "R5");
      for (int i = 0; i < 3; i++) op(1, 2'd0, 4'hF, 32'hC0DE_0000 + i, "R2");
      op(1, 2'd2, 4'hF, 32'h8000_0002, "R9");
      op(0, 2'd1, 4'hF, 0, "R9");
      op(0, 2'd0, 4'hF, 0, "R9");

      // constrained random mix
      for (int k = 0; k < 4000; k++) begin
         int c;
         logic [3:0] be;
         c  = $urandom_range(99, 0);
         be = ($urandom_range(9, 0) == 0) ? 4'($urandom_range(14, 0)) : 4'hF;
         if (c < 40)      op(1, 2'd0, be, $urandom, "R2");
         else if (c < 75) op(0, 2'd0, be, 0, "R2");
         else if (c < 88) op(0, 2'd1, be, 0, "R3");
         else if (c < 93) op(1, 2'd1, be, $urandom & 32'h0070_0000, "R7");
         else if (c < 97) op(1, 2'd2, be,
                             (($urandom_range(4, 0) == 0) ? 32'h8000_0000 : 32'h0) |
                             32'($urandom_range(16, 0)), "R9");
         else if (c < 99) op(0, 2'd2, be, 0, "R9");
         else             op(0, 2'd3, be, 0, "R10");
      end
      op(0, 2'd1, 4'hF, 0, "R3");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule